// File: doc/BRIEF.md
# Configuration Access Router with Sub-Word Merge

This block sits between a configuration-space requester and a pair of root-port configuration engines. Each request names a bus, device, function, byte offset and access size (byte, halfword or dword), plus write data for writes. The block decides from the bus/device pair and the per-port link-up inputs which of the two ports serves the request. A request that no port can serve is completed locally, without touching either engine.

The engines only move whole dwords. The block therefore narrows every read to the addressed lane. It turns every byte or halfword write into a read of the enclosing dword, a lane replacement and a full-dword write-back. That sequence is atomic: the block accepts nothing new until the whole request has been answered. Requests are handled one at a time, and exactly one response pulse answers each request.

Top module: `cfg_route_merge`

## Requirements
- R1: With `req_bus` = 0, device 0 goes to port 0 and device 1 goes to port 1, whatever `link_up` holds. Any other device on bus 0 has no target.
- R2: Bus 1 device 0 goes to port 0 only while `link_up[0]` is 1. Bus 2 device 0 goes to port 1 only while `link_up[1]` is 1. Every other bus/device pair has no target.
- R3: A read with no target issues no engine operation. It answers with all ones within the access width and `rsp_err` = 0.
- R4: A write with no target issues no engine operation and answers with `rsp_err` = 1.
- R5: `req_size` encodes 0 = byte, 1 = halfword, 2 or 3 = dword. Read data is the engine dword shifted right by `req_off[1:0]`×8 for a byte, by `req_off[1]`×16 for a halfword, or by 0 for a dword. It is then masked to the access width, with the upper bits zero.
- R6: A byte or halfword write first issues an engine read and then an engine write to the same port and dword. The written dword keeps every lane of the data read back except the addressed one, which takes the low bits of `req_wdata`.
- R7: A dword write issues a single engine write carrying `req_wdata` unchanged, whatever the value of `req_off[1:0]`.
- R8: If the read phase of a byte or halfword write ends with `eng_err` = 1, no write-back is issued and the response has `rsp_err` = 1.
- R9: A read that ends with `eng_err` = 1 answers with all ones within the access width and `rsp_err` = 1. A write whose engine write ends with `eng_err` = 1 answers with `rsp_err` = 1. Write responses carry `rsp_rdata` = 0.
- R10: `req_ready` is low from the cycle after a request is accepted until its response has been given. `rsp_valid` is a single-cycle pulse, one per request.
- R11: While an engine operation is pending, it carries the request's bus, device and function and `eng_dword` = `req_off[11:2]`. These fields stay stable until `eng_done`.
- R12: After reset, `req_ready` = 1, `rsp_valid` = 0 and `eng_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_up | input | 2 | Link-up status per root port |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_bus | input | BUS_W | Bus number |
| req_dev | input | DEV_W | Device number |
| req_func | input | FUNC_W | Function number |
| req_off | input | OFF_W | Byte offset in configuration space |
| req_wdata | input | DATA_W | Write data, right-aligned |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DATA_W | Read data, right-aligned |
| rsp_err | output | 1 | Request failed |
| eng_valid | output | 1 | Engine operation pending |
| eng_write | output | 1 | Engine operation is a write |
| eng_port | output | 1 | Root port selected |
| eng_bus | output | BUS_W | Bus number to engine |
| eng_dev | output | DEV_W | Device number to engine |
| eng_func | output | FUNC_W | Function number to engine |
| eng_dword | output | OFF_W-2 | Dword index in configuration space |
| eng_wdata | output | DATA_W | Dword to write |
| eng_done | input | 1 | Engine operation finished |
| eng_rdata | input | DATA_W | Dword read by the engine |
| eng_err | input | 1 | Engine operation failed |

## Verification
The checker assumes the engine raises `eng_done` only while `eng_valid` is high, and for one cycle per operation. Its ordering properties depend on this, for example that a clean read completion is followed either by nothing or by a write to the same dword. The bench engine model follows that rule: it answers at a falling edge after a random wait and drops `eng_done` at the next falling edge. `link_up` and all request fields are held steady from the moment a request is offered until its response, so routing is judged on one stable value. The engine's error input is raised only for whole requests, which exercises the abort and error-fill paths cleanly.

// File: rtl/cfgrm_pkg.sv
package cfgrm_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WALT = 2'd3
   } size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2,
      ST_RSP  = 2'd3
   } seq_state_e;

   function automatic logic is_full(input logic [1:0] sz);
      return sz[1];
   endfunction

endpackage

// File: rtl/cfgrm_route.sv
module cfgrm_route #(
   parameter int BUS_W = 8,
   parameter int DEV_W = 5
) (
   input  logic [BUS_W-1:0] bus,
   input  logic [DEV_W-1:0] dev,
   input  logic [1:0]       link_up,
   output logic             hit,
   output logic             port
);
   localparam logic [BUS_W-1:0] BUS_ROOT = '0;
   localparam logic [BUS_W-1:0] BUS_P0   = BUS_W'(1);
   localparam logic [BUS_W-1:0] BUS_P1   = BUS_W'(2);
   localparam logic [DEV_W-1:0] DEV_0    = '0;
   localparam logic [DEV_W-1:0] DEV_1    = DEV_W'(1);

   always_comb begin
      hit  = 1'b0;
      port = 1'b0;
      if (bus == BUS_ROOT) begin
         if (dev == DEV_0) begin
            hit = 1'b1;
         end else if (dev == DEV_1) begin
            hit  = 1'b1;
            port = 1'b1;
         end
      end else if (bus == BUS_P0 && dev == DEV_0 && link_up[0]) begin
         hit = 1'b1;
      end else if (bus == BUS_P1 && dev == DEV_0 && link_up[1]) begin
         hit  = 1'b1;
         port = 1'b1;
      end
   end
endmodule

// File: rtl/cfgrm_lane.sv
module cfgrm_lane #(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        size,
   input  logic [1:0]        off_lo,
   input  logic [DATA_W-1:0] word,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] rd_ext,
   output logic [DATA_W-1:0] merged
);
   localparam int SH_W  = $clog2(DATA_W);
   localparam int LANES = DATA_W / 8;

   logic [SH_W-1:0]   shift;
   logic [DATA_W-1:0] lane_mask;
   logic [DATA_W-1:0] ins;

   always_comb begin
      unique case (size)
         cfgrm_pkg::SZ_BYTE: begin
            shift = SH_W'({off_lo, 3'b000});
            mask  = DATA_W'(8'hFF);
         end
         cfgrm_pkg::SZ_HALF: begin
            shift = SH_W'({off_lo[1], 4'b0000});
            mask  = DATA_W'(16'hFFFF);
         end
         default: begin
            shift = '0;
            mask  = '1;
         end
      endcase
      rd_ext    = (word >> shift) & mask;
      lane_mask = mask << shift;
      ins       = (wdata & mask) << shift;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign merged[8*i +: 8] = lane_mask[8*i] ? ins[8*i +: 8] : word[8*i +: 8];
   end
endmodule

// File: rtl/cfgrm_seq.sv
module cfgrm_seq #(
   parameter int BUS_W  = 8,
   parameter int DEV_W  = 5,
   parameter int FUNC_W = 3,
   parameter int OFF_W  = 12,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [BUS_W-1:0]  req_bus,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [FUNC_W-1:0] req_func,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              hit,
   input  logic              hit_port,
   input  logic [DATA_W-1:0] lane_mask,
   input  logic [DATA_W-1:0] lane_ext,
   input  logic [DATA_W-1:0] lane_merged,
   output logic [1:0]        cur_size,
   output logic [1:0]        cur_off_lo,
   output logic [DATA_W-1:0] cur_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              eng_valid,
   output logic              eng_write,
   output logic              eng_port,
   output logic [BUS_W-1:0]  eng_bus,
   output logic [DEV_W-1:0]  eng_dev,
   output logic [FUNC_W-1:0] eng_func,
   output logic [OFF_W-3:0]  eng_dword,
   output logic [DATA_W-1:0] eng_wdata,
   input  logic              eng_done,
   input  logic              eng_err
);
   import cfgrm_pkg::*;

   seq_state_e        st;
   logic              r_write, r_port, r_ones, r_err;
   logic [1:0]        r_size;
   logic [BUS_W-1:0]  r_bus;
   logic [DEV_W-1:0]  r_dev;
   logic [FUNC_W-1:0] r_func;
   logic [OFF_W-1:0]  r_off;
   logic [DATA_W-1:0] r_wdata, r_wd, r_rsp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         r_write <= 1'b0;
         r_port  <= 1'b0;
         r_ones  <= 1'b0;
         r_err   <= 1'b0;
         r_size  <= '0;
         r_bus   <= '0;
         r_dev   <= '0;
         r_func  <= '0;
         r_off   <= '0;
         r_wdata <= '0;
         r_wd    <= '0;
         r_rsp   <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (req_valid) begin
               r_write <= req_write;
               r_size  <= req_size;
               r_bus   <= req_bus;
               r_dev   <= req_dev;
               r_func  <= req_func;
               r_off   <= req_off;
               r_wdata <= req_wdata;
               r_wd    <= req_wdata;
               r_port  <= hit_port;
               r_rsp   <= '0;
               r_ones  <= 1'b0;
               r_err   <= 1'b0;
               if (!hit) begin
                  r_ones <= !req_write;
                  r_err  <= req_write;
                  st     <= ST_RSP;
               end else if (req_write && is_full(req_size)) begin
                  st <= ST_WR;
               end else begin
                  st <= ST_RD;
               end
            end
            ST_RD: if (eng_done) begin
               if (eng_err) begin
                  r_ones <= !r_write;
                  r_err  <= 1'b1;
                  st     <= ST_RSP;
               end else if (r_write) begin
                  r_wd <= lane_merged;
                  st   <= ST_WR;
               end else begin
                  r_rsp <= lane_ext;
                  st    <= ST_RSP;
               end
            end
            ST_WR: if (eng_done) begin
               r_err <= eng_err;
               st    <= ST_RSP;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (st == ST_IDLE);
   assign rsp_valid  = (st == ST_RSP);
   assign rsp_rdata  = r_ones ? lane_mask : r_rsp;
   assign rsp_err    = r_err;
   assign eng_valid  = (st == ST_RD) || (st == ST_WR);
   assign eng_write  = (st == ST_WR);
   assign eng_port   = r_port;
   assign eng_bus    = r_bus;
   assign eng_dev    = r_dev;
   assign eng_func   = r_func;
   assign eng_dword  = r_off[OFF_W-1:2];
   assign eng_wdata  = r_wd;
   assign cur_size   = r_size;
   assign cur_off_lo = r_off[1:0];
   assign cur_wdata  = r_wdata;
endmodule

// File: rtl/cfg_route_merge.sv
module cfg_route_merge #(
   parameter int BUS_W  = 8,
   parameter int DEV_W  = 5,
   parameter int FUNC_W = 3,
   parameter int OFF_W  = 12,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        link_up,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [BUS_W-1:0]  req_bus,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [FUNC_W-1:0] req_func,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              eng_valid,
   output logic              eng_write,
   output logic              eng_port,
   output logic [BUS_W-1:0]  eng_bus,
   output logic [DEV_W-1:0]  eng_dev,
   output logic [FUNC_W-1:0] eng_func,
   output logic [OFF_W-3:0]  eng_dword,
   output logic [DATA_W-1:0] eng_wdata,
   input  logic              eng_done,
   input  logic [DATA_W-1:0] eng_rdata,
   input  logic              eng_err
);
   if (DATA_W != 32) begin : g_bad_data
      $error("cfg_route_merge: DATA_W must be 32");
   end
   if (OFF_W < 3) begin : g_bad_off
      $error("cfg_route_merge: OFF_W must be at least 3");
   end
   if (BUS_W < 2 || DEV_W < 1) begin : g_bad_addr
      $error("cfg_route_merge: bus or device field too narrow");
   end

   logic              hit, hit_port;
   logic [1:0]        cur_size, cur_off_lo;
   logic [DATA_W-1:0] cur_wdata, lane_mask, lane_ext, lane_merged;

   cfgrm_route #(.BUS_W(BUS_W), .DEV_W(DEV_W)) u_route (
      .bus(req_bus), .dev(req_dev), .link_up(link_up),
      .hit(hit), .port(hit_port)
   );

   cfgrm_lane #(.DATA_W(DATA_W)) u_lane (
      .size(cur_size), .off_lo(cur_off_lo), .word(eng_rdata), .wdata(cur_wdata),
      .mask(lane_mask), .rd_ext(lane_ext), .merged(lane_merged)
   );

   cfgrm_seq #(
      .BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_size(req_size), .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
      .req_off(req_off), .req_wdata(req_wdata),
      .hit(hit), .hit_port(hit_port),
      .lane_mask(lane_mask), .lane_ext(lane_ext), .lane_merged(lane_merged),
      .cur_size(cur_size), .cur_off_lo(cur_off_lo), .cur_wdata(cur_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .eng_valid(eng_valid), .eng_write(eng_write), .eng_port(eng_port),
      .eng_bus(eng_bus), .eng_dev(eng_dev), .eng_func(eng_func),
      .eng_dword(eng_dword), .eng_wdata(eng_wdata),
      .eng_done(eng_done), .eng_err(eng_err)
   );
endmodule

// File: rtl/cfgrm_chk.sv
module cfgrm_chk #(
   parameter int OFF_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             eng_valid,
   input logic             eng_write,
   input logic             eng_port,
   input logic [OFF_W-3:0] eng_dword,
   input logic             eng_done,
   input logic             eng_err
);
   // R10
   busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_valid |-> !req_ready);

   // R10
   accept_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R10
   rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R11
   eng_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_valid && !eng_done) |=> (eng_valid && $stable(eng_write)
                                    && $stable(eng_dword) && $stable(eng_port)));

   // R6
   rmw_same_dword_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_valid && eng_done && !eng_write && !eng_err) |=>
         (!eng_valid || (eng_write && $stable(eng_dword) && $stable(eng_port))));

   // R8
   rmw_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_valid && eng_done && !eng_write && eng_err) |=> !eng_valid);
endmodule

bind cfg_route_merge cfgrm_chk #(.OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .eng_valid(eng_valid), .eng_write(eng_write),
   .eng_port(eng_port), .eng_dword(eng_dword), .eng_done(eng_done), .eng_err(eng_err)
);

// File: tb/cfg_route_merge_bench.sv
module cfg_route_merge_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [1:0]  link_up = 2'b00;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_func = '0;
   logic [11:0] req_off = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic        eng_valid, eng_write, eng_port;
   logic [7:0]  eng_bus;
   logic [4:0]  eng_dev;
   logic [2:0]  eng_func;
   logic [9:0]  eng_dword;
   logic [31:0] eng_wdata;
   logic        eng_done = 1'b0, eng_err = 1'b0;
   logic [31:0] eng_rdata = '0;

   int unsigned n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0;
   logic        inj_err = 1'b0;
   logic        last_port = 1'b0;
   logic [9:0]  last_dword = '0;
   logic [7:0]  last_bus = '0;
   logic [31:0] mem [0:1][0:63];
   bit          finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_route_merge u_cfg_route_merge (
      .clk(clk), .rst_n(rst_n), .link_up(link_up),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_size(req_size), .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
      .req_off(req_off), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .eng_valid(eng_valid), .eng_write(eng_write), .eng_port(eng_port),
      .eng_bus(eng_bus), .eng_dev(eng_dev), .eng_func(eng_func),
      .eng_dword(eng_dword), .eng_wdata(eng_wdata),
      .eng_done(eng_done), .eng_rdata(eng_rdata), .eng_err(eng_err)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] f_mask(input logic [1:0] sz);
      return sz[1] ? 32'hFFFF_FFFF : (sz[0] ? 32'h0000_FFFF : 32'h0000_00FF);
   endfunction

   function automatic int f_shift(input logic [1:0] sz, input logic [11:0] off);
      return sz[1] ? 0 : (sz[0] ? 16 * off[1] : 8 * off[1:0]);
   endfunction

   function automatic logic [32:0] f_route(input logic [7:0] b, input logic [4:0] d, input logic [1:0] lk);
      if (b == 0 && d == 0) return {1'b1, 32'd0};
      if (b == 0 && d == 1) return {1'b1, 32'd1};
      if (b == 1 && d == 0 && lk[0]) return {1'b1, 32'd0};
      if (b == 2 && d == 0 && lk[1]) return {1'b1, 32'd1};
      return {1'b0, 32'd0};
   endfunction

   // Engine model: answers at a falling edge after a random wait.
   initial begin
      forever begin
         @(negedge clk);
         if (eng_done) begin
            eng_done = 1'b0;
            eng_err  = 1'b0;
         end else if (rst_n && eng_valid && ($urandom % 2 == 0)) begin
            last_port  = eng_port;
            last_dword = eng_dword;
            last_bus   = eng_bus;
            if (eng_write) begin
               n_wr++;
               if (!inj_err) mem[eng_port][eng_dword[5:0]] = eng_wdata;
            end else begin
               n_rd++;
               eng_rdata = inj_err ? $urandom : mem[eng_port][eng_dword[5:0]];
            end
            eng_err  = inj_err;
            eng_done = 1'b1;
         end
      end
   end

   task automatic access(input bit wr, input logic [1:0] sz, input logic [7:0] b,
                         input logic [4:0] d, input logic [2:0] fn,
                         input logic [11:0] off, input logic [31:0] wd, input bit ie);
      logic [32:0] rt;
      logic        hit, prt;
      logic [31:0] old, exp_rd, exp_mem, got_rd;
      bit          exp_err, got_err;
      int unsigned rd0, wr0, exp_nrd, exp_nwr, sh;
      rt  = f_route(b, d, link_up);
      hit = rt[32];
      prt = rt[0];
      old = mem[prt][off[7:2]];
      sh  = f_shift(sz, off);
      inj_err = ie;
      rd0 = n_rd;
      wr0 = n_wr;
      req_write = wr; req_size = sz; req_bus = b; req_dev = d; req_func = fn;
      req_off = off; req_wdata = wd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!rsp_valid || !hit ? 1'b1 : 1'b0, "R10 response too early", {31'd0, rsp_valid}, 32'd0);
      chk(req_ready == 1'b0, "R10 busy after accept", {31'd0, req_ready}, 32'd0);
      while (!rsp_valid && !finished) @(negedge clk);
      got_rd  = rsp_rdata;
      got_err = rsp_err;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R10 single response", {31'd0, rsp_valid}, 32'd0);
      inj_err = 1'b0;
      if (!hit) begin
         exp_rd = wr ? 32'd0 : f_mask(sz);
         exp_err = wr;
         exp_nrd = 0; exp_nwr = 0;
         exp_mem = old;
      end else begin
         exp_nrd = (!wr || !sz[1]) ? 1 : 0;
         exp_nwr = (wr && (sz[1] || !ie)) ? 1 : 0;
         exp_err = ie;
         if (wr) exp_rd = 32'd0;
         else if (ie) exp_rd = f_mask(sz);
         else exp_rd = (old >> sh) & f_mask(sz);
         if (wr && !ie)
            exp_mem = sz[1] ? wd : ((old & ~(f_mask(sz) << sh)) | ((wd & f_mask(sz)) << sh));
         else
            exp_mem = old;
      end
      chk(got_rd == exp_rd, wr ? "R9 write rdata" : (hit ? (ie ? "R9 error fill" : "R5 read lane") : "R3 no-target read"),
          got_rd, exp_rd);
      chk(got_err == exp_err, hit ? (ie ? "R8 R9 error flag" : "R5 status") : (wr ? "R4 no-target write" : "R3 status"),
          {31'd0, got_err}, {31'd0, exp_err});
      chk((n_rd - rd0) == exp_nrd && (n_wr - wr0) == exp_nwr,
          hit ? (wr ? (sz[1] ? "R7 op count" : "R6 R8 op count") : "R5 op count") : "R3 R4 no engine op",
          (n_rd - rd0) * 16 + (n_wr - wr0), exp_nrd * 16 + exp_nwr);
      if (hit) begin
         chk(mem[prt][off[7:2]] == exp_mem, sz[1] ? "R7 dword written" : "R6 merged dword",
             mem[prt][off[7:2]], exp_mem);
         chk(last_port == prt, (b == 0) ? "R1 port select" : "R2 port select",
             {31'd0, last_port}, {31'd0, prt});
         chk(last_dword == off[11:2] && last_bus == b, "R11 engine address",
             {14'd0, last_bus, last_dword}, {14'd0, b, off[11:2]});
      end
   endtask

   initial begin
      for (int p = 0; p < 2; p++)
         for (int i = 0; i < 64; i++) mem[p][i] = 32'h1000_0000 * (p + 1) + 32'h0101 * i;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && rsp_valid == 1'b0 && eng_valid == 1'b0, "R12 reset state",
          {29'd0, req_ready, rsp_valid, eng_valid}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: bus 0 routing independent of link status
      link_up = 2'b00;
      access(0, 2'd2, 8'd0, 5'd0, 3'd0, 12'h010, 0, 0);
      access(0, 2'd2, 8'd0, 5'd1, 3'd0, 12'h014, 0, 0);
      access(0, 2'd0, 8'd0, 5'd2, 3'd0, 12'h000, 0, 0);   // R3 byte -> FF
      // R2: downstream buses gated by link bits
      access(0, 2'd1, 8'd1, 5'd0, 3'd0, 12'h022, 0, 0);   // no target -> FFFF
      access(1, 2'd2, 8'd2, 5'd0, 3'd0, 12'h020, 32'hDEAD_BEEF, 0); // R4
      link_up = 2'b11;
      access(0, 2'd1, 8'd1, 5'd0, 3'd1, 12'h022, 0, 0);
      access(0, 2'd0, 8'd2, 5'd0, 3'd2, 12'h023, 0, 0);
      access(0, 2'd2, 8'd1, 5'd1, 3'd0, 12'h020, 0, 0);   // device 1 on bus 1: none
      // R6 sub-word writes, R7 dword with odd low bits
      access(1, 2'd0, 8'd0, 5'd0, 3'd0, 12'h033, 32'hFFFF_FFA5, 0);
      access(1, 2'd1, 8'd0, 5'd1, 3'd0, 12'h036, 32'h1234_C3D2, 0);
      access(1, 2'd3, 8'd2, 5'd0, 3'd0, 12'h047, 32'hCAFE_F00D, 0);
      // R8 read-phase error aborts, R9 error paths
      access(1, 2'd0, 8'd0, 5'd0, 3'd0, 12'h051, 32'h77, 1);
      access(0, 2'd0, 8'd0, 5'd1, 3'd0, 12'h052, 0, 1);
      access(1, 2'd2, 8'd1, 5'd0, 3'd0, 12'h058, 32'h0BAD_0BAD, 1);
      // Random mix
      for (int n = 0; n < 400; n++) begin
         if (n % 8 == 0) link_up = 2'($urandom);
         access(1'($urandom), 2'($urandom), 8'($urandom % 4), 5'($urandom % 3), 3'($urandom),
                12'($urandom), $urandom, ($urandom % 12) == 0);
      end
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected 0", WATCHDOG);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule